// File: doc/BRIEF.md
# Serial ADC Result Output Register

This block is the digital back end of a serial-output converter. It keeps the most recent 12-bit conversion result in an output word. An externally supplied serial clock shifts that word out as a 16-bit frame: four zero bits, then the result with its most significant bit first. Once the frame is complete, the data line is released: the output enable drops and the data bit is held at zero. The analog conversion is not modelled. A one-cycle result strobe, synchronous to the system clock, carries the finished 12-bit value in its place.

Both the serial clock and the active-low convert-start input are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. For this to work, the system clock must run at least four times faster than the serial clock.

Two overlaps are handled. A result that arrives while a frame is being read is parked in a pending slot, so the frame in flight never changes underneath the reader. That pending result is loaded when the frame's last falling edge arrives. If the reader has not finished by the next convert-start falling edge, the pending result is loaded on that edge instead, and the frame position is reset.

Top module: `adc_outreg`

## Requirements
- R1: After reset, `sdata_oe` is 0, `sdata_out` is 0 and the frame position is at its first bit.
- R2: Each synchronized serial-clock rising edge drives the next frame bit, which then holds through the following falling edge. Bit order is four zeros, then result bits 11 down to 0. Bit 0 is the 16th bit.
- R3: On the 16th serial-clock falling edge, `sdata_oe` drops to 0. While `sdata_oe` is 0, `sdata_out` is 0.
- R4: A result strobe that arrives while no frame is being read loads the output word at once. The next frame then carries that value.
- R5: A result strobe that arrives between a frame's first rising edge and its 16th falling edge does not change the frame being read. That result is loaded at the 16th falling edge.
- R6: A second strobe that arrives while a result is already pending replaces the pending value, so the newest result is the one loaded.
- R7: A convert-start falling edge while the serial clock is low does three things: it resets the frame to its first bit, it drops `sdata_oe`, and it loads any pending result.
- R8: A convert-start falling edge while the serial clock is high is ignored. The frame in progress continues from its current position.
- R9: A rising edge after the 16th bit restarts the frame from its first zero bit. From then on, `sdata_oe` stays 1 after the clock stops, until a convert-start falling edge (R7).
- R10: Pauses of any length with the serial clock low inside a frame keep the bit position.
- R11: The outputs change on the third system-clock rising edge after a serial-clock edge at the input. They remain unchanged on the first two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial read clock, asynchronous |
| start_n_in | input | 1 | Convert-start, active low, asynchronous |
| result_valid | input | 1 | One-cycle strobe marking a finished conversion |
| result_data | input | 12 | Conversion result carried with the strobe |
| sdata_out | output | 1 | Serial data bit, 0 while released |
| sdata_oe | output | 1 | High while the data line is driven |

## Verification
A serial-clock edge takes three system-clock edges to reach the outputs: two synchronizer stages, then the register that records the previous level and feeds the edge detector, with the frame registers loading on the third edge. The bench therefore drives every input on a falling system-clock edge. It holds each serial-clock level for five system cycles and samples the data bit four falling edges after a rising serial-clock edge, well inside the stable window. The R11 check counts the edges directly: it samples at the first, second and third falling edges after a rising serial-clock edge and expects the enable to change only at the third. A result strobe loads the output word one system cycle after it arrives, so the bench sees its effect in the next frame that is read.

// File: rtl/adc_outreg_pkg.sv
package adc_outreg_pkg;
  // Frame length from the result width and the count of leading zero bits.
  function automatic int frame_len(input int res_w, input int lead_w);
    return res_w + lead_w;
  endfunction

  // Counter width that can hold every value from 0 up to the frame length.
  function automatic int cnt_width(input int res_w, input int lead_w);
    return $clog2(res_w + lead_w + 1);
  endfunction
endpackage

// File: rtl/adc_outreg_edge_sync.sv
module adc_outreg_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = async_in;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], async_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/adc_outreg_shifter.sv
module adc_outreg_shifter
  import adc_outreg_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4,
  localparam int FRAME = frame_len(RES_W, LEAD_W),
  localparam int CNT_W = cnt_width(RES_W, LEAD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             frame_rst,
  input  logic [RES_W-1:0] word_i,
  output logic             sdata_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME);

  logic [CNT_W-1:0] cnt_q, cnt_d, idx;
  logic             oe_q, oe_d, bit_q, bit_d, busy_q, busy_d, ovr_q, ovr_d;
  logic [RES_W-1:0] shifted;
  logic             frame_bit;
  logic             last_fall;

  // Bit at position idx: a zero in the lead-in, otherwise the result MSB first.
  always_comb begin
    shifted = word_i << (int'(idx) - LEAD_W);
    if (int'(idx) < LEAD_W) frame_bit = 1'b0;
    else                    frame_bit = shifted[RES_W-1];
  end

  assign last_fall = fall_ev && busy_q && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    ovr_d  = ovr_q;
    idx    = '0;
    if (frame_rst) begin
      cnt_d  = '0;
      oe_d   = 1'b0;
      bit_d  = 1'b0;
      busy_d = 1'b0;
      ovr_d  = 1'b0;
    end else if (rise_ev) begin
      if (cnt_q == LAST) begin
        idx   = '0;
        ovr_d = 1'b1;
      end else begin
        idx = cnt_q;
      end
      cnt_d  = idx + CNT_W'(1);
      oe_d   = 1'b1;
      busy_d = 1'b1;
      bit_d  = frame_bit;
    end else if (last_fall) begin
      busy_d = 1'b0;
      if (!ovr_q) begin
        oe_d  = 1'b0;
        bit_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      bit_q  <= 1'b0;
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
      ovr_q  <= ovr_d;
    end
  end

  assign sdata_o = bit_q;
  assign oe_o    = oe_q;
  assign busy_o  = busy_q;
  assign done_o  = last_fall && !frame_rst;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/adc_outreg_hold.sv
module adc_outreg_hold #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             start_ev,
  output logic [RES_W-1:0] word_o
);
  logic [RES_W-1:0] word_q, word_d, pend_q, pend_d;
  logic             pv_q, pv_d;
  logic             read_open;

  // A frame is open if it is busy and neither finishing nor being reset now.
  assign read_open = busy_i && !done_i && !start_ev;

  always_comb begin
    word_d = word_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (strobe_i) begin
      if (read_open) begin
        pend_d = data_i;
        pv_d   = 1'b1;
      end else begin
        word_d = data_i;
        pv_d   = 1'b0;
      end
    end else if ((done_i || start_ev) && pv_q) begin
      word_d = pend_q;
      pv_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_outreg.sv
module adc_outreg
  import adc_outreg_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int LEAD_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = cnt_width(RES_W, LEAD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             start_n_in,
  input  logic             result_valid,
  input  logic [RES_W-1:0] result_data,
  output logic             sdata_out,
  output logic             sdata_oe
);
  logic [1:0]       rst_pipe_q;
  logic             rst_ni;
  logic             sclk_lvl, sclk_prev, st_lvl, st_prev;
  logic             rise_ev, fall_ev, cs_ev;
  logic             busy, done;
  logic [CNT_W-1:0] cnt;
  logic [RES_W-1:0] word;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  adc_outreg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_ni), .async_in(sclk_in),
    .level_o(sclk_lvl), .prev_o(sclk_prev));

  adc_outreg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_start_sync (
    .clk(clk), .rst_n(rst_ni), .async_in(start_n_in),
    .level_o(st_lvl), .prev_o(st_prev));

  assign rise_ev = sclk_lvl && !sclk_prev;
  assign fall_ev = !sclk_lvl && sclk_prev;
  assign cs_ev   = !st_lvl && st_prev && !sclk_lvl;

  adc_outreg_shifter #(.RES_W(RES_W), .LEAD_W(LEAD_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .frame_rst(cs_ev), .word_i(word), .sdata_o(sdata_out), .oe_o(sdata_oe),
    .busy_o(busy), .done_o(done), .cnt_o(cnt));

  adc_outreg_hold #(.RES_W(RES_W)) u_hold (
    .clk(clk), .rst_n(rst_ni), .strobe_i(result_valid), .data_i(result_data),
    .busy_i(busy), .done_i(done), .start_ev(cs_ev), .word_o(word));
endmodule

// File: rtl/adc_outreg_chk.sv
module adc_outreg_chk #(
  parameter int RES_W = 12,
  parameter int FRAME = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdata_out,
  input logic             sdata_oe,
  input logic             rise_ev,
  input logic             fall_ev,
  input logic             cs_ev,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [RES_W-1:0] word
);
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= FRAME);

  a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_ev && !fall_ev && !cs_ev) |=> $stable(sdata_out));

  a_r2_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(rise_ev));

  a_r3_oe_off_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> $past(fall_ev || cs_ev));

  a_r3_zero_released: assert property (@(posedge clk) disable iff (!rst_n)
    !sdata_oe |-> !sdata_out);

  a_r5_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev && !cs_ev) |=> $stable(word));

  a_r7_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    cs_ev |=> (cnt == '0 && !sdata_oe));
endmodule

bind adc_outreg adc_outreg_chk #(
  .RES_W(RES_W), .FRAME(RES_W + LEAD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .cs_ev(cs_ev), .busy(busy),
  .cnt(cnt), .word(word));

// File: tb/adc_outreg_test.sv
module adc_outreg_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  localparam logic [11:0] VEC [NVEC] = '{12'hA5C, 12'h000, 12'hFFF, 12'h801, 12'h3C7, 12'h5A5};

  logic clk, rst_n, sclk_in, start_n_in, result_valid;
  logic [11:0] result_data;
  logic sdata_out, sdata_oe;
  int n_run, n_fail;
  bit finished;

  adc_outreg uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .start_n_in(start_n_in),
    .result_valid(result_valid), .result_data(result_data),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output logic b, output logic o);
    sclk_in = 1'b1; wait_n(4);
    b = sdata_out; o = sdata_oe;
    wait_n(1);
    sclk_in = 1'b0; wait_n(5);
  endtask

  task automatic read_bits(input int n, input int gap, inout logic [15:0] w, inout int oe_bad);
    for (int i = 0; i < n; i++) begin
      logic b, o;
      pulse(b, o);
      w = {w[14:0], b};
      if (!o) oe_bad++;
      if (gap > 0 && (i == 2 || i == 8)) wait_n(gap);
    end
  endtask

  task automatic start_pulse();
    start_n_in = 1'b0; wait_n(5);
    start_n_in = 1'b1; wait_n(5);
  endtask

  task automatic strobe(input logic [11:0] d);
    result_valid = 1'b1; result_data = d;
    wait_n(1);
    result_valid = 1'b0;
    wait_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int bad;
    logic b, o;
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; sclk_in = 1'b0; start_n_in = 1'b1;
    result_valid = 1'b0; result_data = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);

    // R1: reset state
    check(sdata_oe == 1'b0, "R1 oe after reset", 32'(sdata_oe), 0);
    check(sdata_out == 1'b0, "R1 data after reset", 32'(sdata_out), 0);

    // R11: enable changes on the third system edge after the SCLK rise
    start_pulse();
    strobe(12'h9B3);
    sclk_in = 1'b1;
    wait_n(1); check(sdata_oe == 1'b0, "R11 edge1", 32'(sdata_oe), 0);
    wait_n(1); check(sdata_oe == 1'b0, "R11 edge2", 32'(sdata_oe), 0);
    wait_n(1); check(sdata_oe == 1'b1, "R11 edge3", 32'(sdata_oe), 1);
    wait_n(3); sclk_in = 1'b0; wait_n(5);
    start_pulse();
    check(sdata_oe == 1'b0, "R7 oe dropped by start", 32'(sdata_oe), 0);

    // Table walk: R2, R3, R4 (odd entries with pauses for R10)
    for (int k = 0; k < NVEC; k++) begin
      start_pulse();
      strobe(VEC[k]);
      w = '0; bad = 0;
      read_bits(16, (k % 2) ? 37 : 0, w, bad);
      check(w == {4'b0, VEC[k]}, (k % 2) ? "R10 paused frame" : "R2 R4 frame", 32'(w), 32'({4'b0, VEC[k]}));
      check(bad == 0, "R2 oe high during frame", 32'(bad), 0);
      check(sdata_oe == 1'b0 && sdata_out == 1'b0, "R3 released after 16th fall",
            32'({sdata_oe, sdata_out}), 0);
    end

    // R5: strobe during a read is deferred to the end of that read
    start_pulse(); strobe(12'h123);
    w = '0; bad = 0;
    read_bits(5, 0, w, bad);
    strobe(12'hEDC);
    read_bits(11, 0, w, bad);
    check(w == 16'h0123, "R5 frame unchanged", 32'(w), 32'h0123);
    start_pulse(); w = '0;
    read_bits(16, 0, w, bad);
    check(w == 16'h0EDC, "R5 deferred load", 32'(w), 32'h0EDC);

    // R6: newest pending result wins
    start_pulse(); strobe(12'h111);
    w = '0;
    read_bits(3, 0, w, bad);
    strobe(12'h222); strobe(12'h333);
    read_bits(13, 0, w, bad);
    check(w == 16'h0111, "R6 frame unchanged", 32'(w), 32'h0111);
    start_pulse(); w = '0;
    read_bits(16, 0, w, bad);
    check(w == 16'h0333, "R6 newest wins", 32'(w), 32'h0333);

    // R7: start mid-read loads pending and restarts the frame
    start_pulse(); strobe(12'h456);
    w = '0;
    read_bits(6, 0, w, bad);
    strobe(12'hBCD);
    start_pulse();
    check(sdata_oe == 1'b0, "R7 oe off after start", 32'(sdata_oe), 0);
    w = '0;
    read_bits(16, 0, w, bad);
    check(w == 16'h0BCD, "R7 pending loaded, frame restarted", 32'(w), 32'h0BCD);

    // R8: start edge with SCLK high is ignored
    start_pulse(); strobe(12'h6E9);
    w = '0;
    read_bits(6, 0, w, bad);
    sclk_in = 1'b1; wait_n(4);
    b = sdata_out; w = {w[14:0], b};
    start_n_in = 1'b0; wait_n(5);
    sclk_in = 1'b0; wait_n(5);
    start_n_in = 1'b1; wait_n(5);
    read_bits(9, 0, w, bad);
    check(w == 16'h06E9, "R8 frame continues", 32'(w), 32'h06E9);

    // R9: extra pulse restarts the frame and keeps the line driven
    start_pulse(); strobe(12'hF0F);
    w = '0;
    read_bits(16, 0, w, bad);
    pulse(b, o);
    check(b == 1'b0 && o == 1'b1, "R9 restart bit", 32'({o, b}), 32'h2);
    wait_n(30);
    check(sdata_oe == 1'b1, "R9 stays driven", 32'(sdata_oe), 1);
    start_pulse();
    check(sdata_oe == 1'b0, "R9 R7 start releases", 32'(sdata_oe), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule